// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Unit

This unit carries out the 64-bit atomic instructions of a RISC-V style integer core. The issue stage gives it a decoded 32-bit instruction word together with the values of its two source registers and pulses a start strobe. The unit then runs its own memory sequence over a single-port request/acknowledge interface. That sequence is one read, or one write, or a read followed by a write. At the end it raises a one-cycle destination-register write strobe.

The supported operations are load-reserved, store-conditional, swap, add, exclusive-or, and, or, and the signed and unsigned forms of minimum and maximum. One reservation register, holding a valid bit and a full address, links a load-reserved to a later store-conditional. The acquire and release bits of the instruction are captured and held on two outputs for the length of the operation, so that the surrounding pipeline can act on them.

Top module: `amo_unit`

## Requirements
- R1: The unit accepts an instruction when `start_i` is high while it is idle. It takes the opcode from bits 6:0 (must be 0101111), the width code from bits 14:12 (must be 011), the operation code from bits 31:27, acquire from bit 26, release from bit 25, the source fields from bits 24:20 and 19:15, and the destination index from bits 11:7.
- R2: A wrong opcode, a wrong width code, or an operation code outside the eleven listed values raises `illegal_o` for exactly one cycle, in the cycle after the start. Such an instruction makes no memory request and produces no register write.
- R3: Every memory request uses the full 64-bit `rs1_val_i` captured at acceptance as its address. A request is high for one cycle only. Read-modify-write operations make exactly one read followed by one write.
- R4: For every read-modify-write operation, the write strobe carries the old memory value and the destination index. The strobe is high for one cycle only.
- R5: The operation codes 00001 (swap), 00000 (add), 00100 (xor), 01100 (and) and 01000 (or) store, respectively, `rs2`, old+`rs2` (modulo 2^64), old^`rs2`, old&`rs2` and old|`rs2`.
- R6: Operation code 10000 stores the smaller of old and `rs2`, and 10100 stores the larger, both compared as two's-complement numbers.
- R7: Operation code 11000 stores the smaller of old and `rs2`, and 11100 stores the larger, both compared as unsigned numbers.
- R8: Operation code 00010 (load-reserved) makes one read, returns the value read, and records a reservation on the address. The reservation is recorded even when the destination index is 0.
- R9: Operation code 00011 (store-conditional), when the held reservation matches the full address, makes one write of `rs2` and returns 0.
- R10: A store-conditional with no matching reservation makes no memory request and returns 1. Every store-conditional clears the reservation, whether it succeeds or fails.
- R11: A destination index of 0 suppresses the write strobe. The memory side effects still take place.
- R12: `busy_o` is high from the cycle after acceptance through the cycle of the write strobe, and low in the cycle after it. A `start_i` that arrives while busy is ignored.
- R13: `ord_aq_o` and `ord_rl_o` show the acquire and release bits of the accepted instruction and stay stable while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction valid strobe |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | First source value (address) |
| rs2_val_i | input | 64 | Second source value (operand) |
| busy_o | output | 1 | Operation in progress |
| illegal_o | output | 1 | One-cycle illegal-instruction flag |
| ord_aq_o | output | 1 | Captured acquire bit |
| ord_rl_o | output | 1 | Captured release bit |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Request address |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | Response strobe for the last request |
| mem_rdata_i | input | 64 | Read data, valid with `mem_ack_i` |
| rd_we_o | output | 1 | Destination write strobe |
| rd_addr_o | output | 5 | Destination index |
| rd_data_o | output | 64 | Destination value |

## Verification
Number the clock edges from the acceptance edge as 1, and let L be the number of cycles the memory takes from a request to its acknowledge. The write strobe then arrives after edge 5+2L for read-modify-write operations, after edge 3+L for load-reserved and for a successful store-conditional, and after edge 1 for a failed store-conditional. The illegal flag is high after edge 1 only. For each instruction the bench computes the edge from the operation kind and the latency it chose for that instruction. It samples all outputs on the falling edge between clock edges, records the edge on which the strobe appears, and compares that edge with the computed one. It also checks that `busy_o` falls one edge later.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [6:0] AMO_OPCODE  = 7'b0101111;
  localparam logic [2:0] AMO_WIDTH64 = 3'b011;
  localparam int         REG_IDX_W   = 5;

  typedef enum logic [3:0] {
    OP_LR, OP_SC, OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
    OP_MIN, OP_MAX, OP_MINU, OP_MAXU
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT_RDATA, ST_WRITE, ST_WAIT_WACK, ST_DONE
  } amo_state_e;

  typedef struct packed {
    logic                 legal;
    amo_op_e              op;
    logic                 aq;
    logic                 rl;
    logic [REG_IDX_W-1:0] rd;
  } amo_dec_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [31:0] instr_i,
  output amo_dec_t    dec_o
);

  logic [4:0] op_code;
  logic       fmt_ok;
  logic       op_known;
  amo_op_e    op_sel;
  logic       unused_src_fields;

  assign op_code           = instr_i[31:27];
  assign fmt_ok            = (instr_i[6:0] == AMO_OPCODE) && (instr_i[14:12] == AMO_WIDTH64);
  assign unused_src_fields = ^instr_i[24:15];

  always_comb begin
    op_known = 1'b1;
    op_sel   = OP_ADD;
    unique case (op_code)
      5'b00010: op_sel = OP_LR;
      5'b00011: op_sel = OP_SC;
      5'b00001: op_sel = OP_SWAP;
      5'b00000: op_sel = OP_ADD;
      5'b00100: op_sel = OP_XOR;
      5'b01100: op_sel = OP_AND;
      5'b01000: op_sel = OP_OR;
      5'b10000: op_sel = OP_MIN;
      5'b10100: op_sel = OP_MAX;
      5'b11000: op_sel = OP_MINU;
      5'b11100: op_sel = OP_MAXU;
      default:  op_known = 1'b0;
    endcase
  end

  always_comb begin
    dec_o.legal = fmt_ok && op_known;
    dec_o.op    = op_sel;
    dec_o.aq    = instr_i[26];
    dec_o.rl    = instr_i[25];
    dec_o.rd    = instr_i[11:7];
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] result_o
);

  logic s_less;
  logic u_less;

  assign s_less = $signed(mem_val_i) < $signed(opnd_i);
  assign u_less = mem_val_i < opnd_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  result_o = mem_val_i + opnd_i;
      OP_XOR:  result_o = mem_val_i ^ opnd_i;
      OP_AND:  result_o = mem_val_i & opnd_i;
      OP_OR:   result_o = mem_val_i | opnd_i;
      OP_MIN:  result_o = s_less ? mem_val_i : opnd_i;
      OP_MAX:  result_o = s_less ? opnd_i : mem_val_i;
      OP_MINU: result_o = u_less ? mem_val_i : opnd_i;
      OP_MAXU: result_o = u_less ? opnd_i : mem_val_i;
      default: result_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] probe_i,
  output logic              hit_o
);

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    valid_d = valid_q;
    if (set_i)      valid_d = 1'b1;
    else if (clr_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (set_i) addr_q <= addr_i;
  end

  assign hit_o = valid_q && (addr_q == probe_i);

  assert_set_clr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i));

  assert_clear_drops_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !hit_o);

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [31:0]          instr_i,
  input  logic [DATA_W-1:0]    rs1_val_i,
  input  logic [DATA_W-1:0]    rs2_val_i,
  output logic                 busy_o,
  output logic                 illegal_o,
  output logic                 ord_aq_o,
  output logic                 ord_rl_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [DATA_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 rd_we_o,
  output logic [REG_IDX_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0]    rd_data_o
);

  localparam logic [DATA_W-1:0] SC_OK   = '0;
  localparam logic [DATA_W-1:0] SC_FAIL = {{(DATA_W-1){1'b0}}, 1'b1};

  amo_dec_t   dec;
  amo_state_e state_q, state_d;
  amo_op_e    op_q;
  logic [REG_IDX_W-1:0] rd_q;
  logic [DATA_W-1:0]    addr_q, opnd_q, wdata_q, wdata_d, rdval_q, rdval_d;
  logic [DATA_W-1:0]    alu_res;
  logic aq_q, rl_q, illegal_q;
  logic accept, take_legal, rdata_take, resv_hit, resv_set, resv_clr;
  logic cap_en, wdata_en, rdval_en;

  amo_decode u_decode (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (op_q),
    .mem_val_i (mem_rdata_i),
    .opnd_i    (opnd_q),
    .result_o  (alu_res)
  );

  amo_resv #(.ADDR_W(DATA_W)) u_resv (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (resv_set),
    .clr_i   (resv_clr),
    .addr_i  (addr_q),
    .probe_i (rs1_val_i),
    .hit_o   (resv_hit)
  );

  assign accept     = start_i && (state_q == ST_IDLE);
  assign take_legal = accept && dec.legal;
  assign rdata_take = (state_q == ST_WAIT_RDATA) && mem_ack_i;
  assign resv_set   = rdata_take && (op_q == OP_LR);
  assign resv_clr   = take_legal && (dec.op == OP_SC);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_legal) begin
          if (dec.op == OP_SC) state_d = resv_hit ? ST_WRITE : ST_DONE;
          else                 state_d = ST_READ;
        end
      end
      ST_READ:       state_d = ST_WAIT_RDATA;
      ST_WAIT_RDATA: if (mem_ack_i) state_d = (op_q == OP_LR) ? ST_DONE : ST_WRITE;
      ST_WRITE:      state_d = ST_WAIT_WACK;
      ST_WAIT_WACK:  if (mem_ack_i) state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // data path next values and enables
  always_comb begin
    cap_en   = take_legal;
    wdata_en = 1'b0;
    rdval_en = 1'b0;
    wdata_d  = wdata_q;
    rdval_d  = rdval_q;
    if (take_legal && (dec.op == OP_SC)) begin
      wdata_en = 1'b1;
      rdval_en = 1'b1;
      wdata_d  = rs2_val_i;
      rdval_d  = resv_hit ? SC_OK : SC_FAIL;
    end else if (rdata_take) begin
      wdata_en = 1'b1;
      rdval_en = 1'b1;
      wdata_d  = alu_res;
      rdval_d  = mem_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= accept && !dec.legal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ADD;
      rd_q   <= '0;
      addr_q <= '0;
      opnd_q <= '0;
      aq_q   <= 1'b0;
      rl_q   <= 1'b0;
    end else if (cap_en) begin
      op_q   <= dec.op;
      rd_q   <= dec.rd;
      addr_q <= rs1_val_i;
      opnd_q <= rs2_val_i;
      aq_q   <= dec.aq;
      rl_q   <= dec.rl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= wdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdval_q <= '0;
    else if (rdval_en) rdval_q <= rdval_d;
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign illegal_o   = illegal_q;
  assign ord_aq_o    = aq_q;
  assign ord_rl_o    = rl_q;
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rd_we_o     = (state_q == ST_DONE) && (rd_q != '0);
  assign rd_addr_o   = rd_q;
  assign rd_data_o   = rdval_q;

  assert_illegal_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!busy_o && !mem_req_o && !rd_we_o));

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |=> (!rd_we_o && !busy_o));

  assert_smax_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_take && op_q == OP_MAX) |->
      ($signed(alu_res) >= $signed(mem_rdata_i) && $signed(alu_res) >= $signed(opnd_q)));

  assert_umin_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_take && op_q == OP_MINU) |-> (alu_res <= mem_rdata_i && alu_res <= opnd_q));

  assert_sc_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_legal && dec.op == OP_SC && !resv_hit) |=> (rd_data_o == SC_FAIL && !mem_req_o && busy_o));

  assert_strobe_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> busy_o);

  assert_order_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(ord_aq_o) && $stable(ord_rl_o)));

endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

  localparam logic [4:0] F_LR = 5'b00010, F_SC = 5'b00011, F_SWAP = 5'b00001,
    F_ADD = 5'b00000, F_XOR = 5'b00100, F_AND = 5'b01100, F_OR = 5'b01000,
    F_MIN = 5'b10000, F_MAX = 5'b10100, F_MINU = 5'b11000, F_MAXU = 5'b11100;
  localparam logic [63:0] BASE = 64'hC3A0_0000_0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] rs1_val_i = '0, rs2_val_i = '0;
  logic busy_o, illegal_o, ord_aq_o, ord_rl_o, mem_req_o, mem_we_o, rd_we_o;
  logic [63:0] mem_addr_o, mem_wdata_o, rd_data_o;
  logic [4:0] rd_addr_o;
  logic mem_ack_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  int checks = 0, fails = 0, cyc = 0;
  int lat_v = 1, req_cnt = 0, cnt = 0;
  logic [63:0] last_addr = '0;
  logic [63:0] mem_m [16];
  logic [63:0] ref_m [16];
  bit resv_v = 0;
  logic [63:0] resv_a = '0;

  always #2.5 clk = ~clk;

  amo_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .busy_o(busy_o),
    .illegal_o(illegal_o), .ord_aq_o(ord_aq_o), .ord_rl_o(ord_rl_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .rd_we_o(rd_we_o), .rd_addr_o(rd_addr_o), .rd_data_o(rd_data_o)
  );

  // memory model: ack lat_v cycles after the request edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ack_i <= 1'b0;
    if (mem_req_o) begin
      req_cnt   <= req_cnt + 1;
      last_addr <= mem_addr_o;
      cnt       <= lat_v;
      if (mem_we_o) mem_m[mem_addr_o[6:3]] <= mem_wdata_o;
      else          mem_rdata_i <= mem_m[mem_addr_o[6:3]];
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) mem_ack_i <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] f5, input logic aq, input logic rl,
                                      input logic [4:0] rd);
    return {f5, aq, rl, 5'd2, 5'd1, 3'b011, rd, 7'b0101111};
  endfunction

  function automatic logic [63:0] combine(input logic [4:0] f5, input logic [63:0] a, input logic [63:0] b);
    case (f5)
      F_SWAP: return b;
      F_ADD:  return a + b;
      F_XOR:  return a ^ b;
      F_AND:  return a & b;
      F_OR:   return a | b;
      F_MIN:  return ($signed(a) < $signed(b)) ? a : b;
      F_MAX:  return ($signed(a) < $signed(b)) ? b : a;
      F_MINU: return (a < b) ? a : b;
      default: return (a < b) ? b : a;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] f5);
    case (f5)
      F_LR: return "R8";
      F_SC: return "R9/R10";
      F_MIN, F_MAX: return "R6";
      F_MINU, F_MAXU: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [4:0] f5, input logic [4:0] rd, input logic [63:0] addr,
                        input logic [63:0] opnd, input logic aq, input logic rl,
                        input int lat, input bit poke);
    int idx, exp_d, strobe_n, end_n, req0, exp_reqs;
    logic [63:0] old, exp_rd, exp_mem, got_rd;
    bit hit;
    idx = int'(addr[6:3]);
    old = ref_m[idx];
    hit = resv_v && (resv_a == addr);
    exp_mem = old;
    if (f5 == F_LR)      begin exp_rd = old; exp_d = 3 + lat; exp_reqs = 1; end
    else if (f5 == F_SC) begin
      exp_rd = hit ? 64'd0 : 64'd1;
      exp_d = hit ? 3 + lat : 1;
      exp_reqs = hit ? 1 : 0;
      if (hit) exp_mem = opnd;
    end else begin exp_rd = old; exp_mem = combine(f5, old, opnd); exp_d = 5 + 2*lat; exp_reqs = 2; end
    lat_v = lat;
    req0 = req_cnt;
    strobe_n = -1; end_n = -1; got_rd = '0;
    @(negedge clk);
    start_i = 1'b1; instr_i = enc(f5, aq, rl, rd); rs1_val_i = addr; rs2_val_i = opnd;
    for (int n = 1; n < 200; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 1) begin
        start_i = 1'b0;
        chk(ord_aq_o == aq && ord_rl_o == rl, "R13 order bits", {62'd0, ord_aq_o, ord_rl_o}, {62'd0, aq, rl});
      end
      if (poke && n == 2) begin
        start_i = 1'b1; instr_i = enc(F_SWAP, 1'b0, 1'b0, 5'd9);
        rs1_val_i = BASE ^ 64'hFF00; rs2_val_i = 64'hDEAD;
      end
      if (poke && n == 3) start_i = 1'b0;
      if (rd_we_o && strobe_n < 0) begin
        strobe_n = n; got_rd = rd_data_o;
        chk(rd_addr_o == rd, "R4 rd index", {59'd0, rd_addr_o}, {59'd0, rd});
      end
      if (!busy_o) begin end_n = n; break; end
    end
    if (rd != 0) begin
      chk(strobe_n == exp_d, {tag_of(f5), " R12 strobe edge"}, 64'(strobe_n), 64'(exp_d));
      chk(got_rd == exp_rd, {tag_of(f5), " R4 rd value"}, got_rd, exp_rd);
    end else begin
      chk(strobe_n < 0, "R11 no strobe for x0", 64'(strobe_n), 64'hFFFF_FFFF_FFFF_FFFF);
    end
    chk(end_n == exp_d + 1, "R12 busy falls", 64'(end_n), 64'(exp_d + 1));
    chk(req_cnt - req0 == exp_reqs, {tag_of(f5), " R3 request count"}, 64'(req_cnt - req0), 64'(exp_reqs));
    if (exp_reqs != 0) chk(last_addr == addr, "R3 address", last_addr, addr);
    chk(mem_m[idx] == exp_mem, {tag_of(f5), " memory word"}, mem_m[idx], exp_mem);
    ref_m[idx] = exp_mem;
    if (f5 == F_LR) begin resv_v = 1; resv_a = addr; end
    if (f5 == F_SC) resv_v = 0;
  endtask

  task automatic run_illegal(input logic [31:0] word);
    int req0;
    req0 = req_cnt;
    @(negedge clk);
    start_i = 1'b1; instr_i = word; rs1_val_i = BASE; rs2_val_i = 64'h1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    chk(illegal_o && !busy_o, "R2 flag raised", {63'd0, illegal_o}, 64'd1);
    @(posedge clk); @(negedge clk);
    chk(!illegal_o && !rd_we_o, "R2 flag one cycle", {63'd0, illegal_o}, 64'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_cnt == req0, "R2 no memory access", 64'(req_cnt), 64'(req0));
  endtask

  function automatic logic [63:0] pick_val();
    case ($urandom_range(0, 5))
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    logic [4:0] ops [11];
    ops = '{F_LR, F_SC, F_SWAP, F_ADD, F_XOR, F_AND, F_OR, F_MIN, F_MAX, F_MINU, F_MAXU};
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      mem_m[i] = {$urandom(), $urandom()};
      ref_m[i] = mem_m[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !illegal_o && !mem_req_o && !rd_we_o, "R12 reset idle", {63'd0, busy_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 field decode with aq/rl and a fixed sample
    ref_m[0] = 64'd5; mem_m[0] = 64'd5;
    run_op(F_ADD, 5'd31, BASE, 64'd7, 1'b1, 1'b0, 1, 1'b0);
    run_op(F_SWAP, 5'd3, BASE, 64'h1234, 1'b0, 1'b1, 2, 1'b1);   // R12 start while busy ignored
    // R2 illegal forms
    run_illegal({F_ADD, 2'b00, 5'd2, 5'd1, 3'b010, 5'd4, 7'b0101111});
    run_illegal({5'b00101, 2'b00, 5'd2, 5'd1, 3'b011, 5'd4, 7'b0101111});
    run_illegal({F_ADD, 2'b00, 5'd2, 5'd1, 3'b011, 5'd4, 7'b0110011});
    // R6/R7 sign corners
    ref_m[1] = 64'hFFFF_FFFF_FFFF_FFFE; mem_m[1] = ref_m[1];
    run_op(F_MIN, 5'd5, BASE + 8, 64'd3, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_MAXU, 5'd5, BASE + 8, 64'd3, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_MAX, 5'd5, BASE + 8, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_MINU, 5'd5, BASE + 8, 64'd1, 1'b0, 1'b0, 3, 1'b0);
    // R8/R9/R10 reservation flows
    run_op(F_SC, 5'd6, BASE + 16, 64'hAA, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_LR, 5'd0, BASE + 16, 64'd0, 1'b1, 1'b1, 2, 1'b0);
    run_op(F_SC, 5'd6, BASE + 16, 64'hBB, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_SC, 5'd6, BASE + 16, 64'hCC, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_LR, 5'd7, BASE + 24, 64'd0, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_SC, 5'd8, BASE + 24 + 64'h0100_0000_0000_0000, 64'hDD, 1'b0, 1'b0, 1, 1'b0);
    run_op(F_SC, 5'd8, BASE + 24, 64'hEE, 1'b0, 1'b0, 1, 1'b0);
    // R11 x0 destination still writes memory
    run_op(F_XOR, 5'd0, BASE + 32, 64'hF0F0, 1'b0, 1'b0, 2, 1'b0);

    for (int k = 0; k < 120; k++) begin
      run_op(ops[$urandom_range(0, 10)], 5'($urandom_range(0, 31)),
             BASE + 64'(8 * $urandom_range(0, 3)), pick_val(),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             $urandom_range(1, 3), 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule